// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block resolves eight interrupt request lines against a programmable rotation of priority. It combines the pending requests, the mask, the lines already in service and a 3-bit rotation offset, and decides whether the processor should be interrupted and which line wins. The decision is registered. Changes on any input show on `irq_o` and `irq_line_o` one clock later.

Request capture, command decoding and the storage of the in-service set and the offset belong to the surrounding controller. On an acknowledge strobe this block returns, in the same cycle, the updates that controller must apply. These are a one-hot in-service set mask, a one-hot request clear mask, and an optional new rotation offset. It also returns the delivered vector and a spurious flag.

Two service modes change how the current service level is computed. In special-mask mode, masked lines drop out of the in-service set. In special-fully-nested mode on a master, the cascade line drops out of it.

Top module: `prio_resolver`

## Requirements
- R1: A line is a candidate when its request bit is 1 and its mask bit is 0. Each line l gets the rank (l − offset) mod 8, where rank 0 is highest. `irq_line_o` reports the candidate with the lowest rank.
- R2: The service rank is the lowest rank among the in-service bits. With `smask_i` = 1, in-service bits of masked lines are excluded first.
- R3: With `sfn_i` = 1 and `master_i` = 1, in-service bit 2 (the cascade line) is excluded from the service rank.
- R4: `irq_o` is 1 one cycle after the inputs present a best candidate rank strictly lower than the service rank. An empty set has rank 8. During reset `irq_o` = 0.
- R5: On `ack_i` with a winner and `aeoi_i` = 0, `isr_set_o` is the one-hot bit of the winning line. With `aeoi_i` = 1 it is zero.
- R6: On `ack_i` with a winner, `aeoi_i` = 1 and `rot_aeoi_i` = 1, `ofs_upd_o` = 1 and `ofs_nxt_o` = (line + 1) mod 8. Otherwise `ofs_upd_o` = 0.
- R7: On `ack_i` with a winner, `irr_clr_o` is the one-hot bit of the winning line when `trig_level_i` for that line is 0 (edge). It is zero when that bit is 1 (level).
- R8: On `ack_i` with no winner in the current cycle, `ack_line_o` = 7 and `spurious_o` = 1, and `isr_set_o`, `irr_clr_o` and `ofs_upd_o` are all zero.
- R9: `vector_o` = {`vec_base_i`[7:3], `ack_line_o`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Pending request bits |
| mask_i | input | 8 | Mask bits (1 = masked) |
| isr_i | input | 8 | In-service bits |
| ofs_i | input | 3 | Priority rotation offset |
| trig_level_i | input | 8 | Per-line trigger type (1 = level, 0 = edge) |
| vec_base_i | input | 8 | Vector base; low 3 bits ignored |
| smask_i | input | 1 | Special-mask mode |
| sfn_i | input | 1 | Special-fully-nested mode |
| master_i | input | 1 | Block acts as master |
| aeoi_i | input | 1 | Automatic end of interrupt |
| rot_aeoi_i | input | 1 | Rotate on automatic end of interrupt |
| ack_i | input | 1 | Acknowledge strobe |
| irq_o | output | 1 | Registered interrupt request |
| irq_line_o | output | 3 | Registered winning line |
| ack_line_o | output | 3 | Line delivered on acknowledge (7 if spurious) |
| vector_o | output | 8 | Delivered vector |
| spurious_o | output | 1 | Acknowledge found no winner |
| isr_set_o | output | 8 | In-service bits to set |
| irr_clr_o | output | 8 | Request bits to clear |
| ofs_upd_o | output | 1 | Load new rotation offset |
| ofs_nxt_o | output | 3 | New rotation offset |

## Verification
The embedded properties check, on every cycle, the following:
- a raised `irq_o` points at a line that was requested and unmasked one cycle earlier;
- the set and clear masks are at most one-hot;
- a clear never touches a level-triggered line;
- a spurious acknowledge and an offset update produce no in-service change.

Only the bench's scenarios can show that the chosen line is the right one under rotation. The same holds for the strict comparison against the service rank and for the special-mask and cascade exclusions. The bench checks these with directed corner cases and a broad sweep against an arithmetic rank model.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;
  localparam int unsigned CASCADE_LINE_DEF = 2;

  typedef struct packed {
    logic smask;
    logic sfn;
    logic master;
    logic aeoi;
    logic rot_aeoi;
  } prio_mode_t;
endpackage

// File: rtl/prio_scan.sv
module prio_scan #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  bits_i,
  input  logic [IW-1:0] ofs_i,
  output logic [IW:0]   idx_o   // N when empty
);
  logic [IW-1:0] ln;

  always_comb begin
    idx_o = (IW+1)'(N);
    ln    = '0;
    for (int p = N - 1; p >= 0; p--) begin
      ln = ofs_i + IW'(p);
      if (bits_i[ln]) idx_o = (IW+1)'(p);
    end
  end
endmodule

// File: rtl/ack_unit.sv
module ack_unit
  import prio_res_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned VW = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ack_i,
  input  logic          win_i,
  input  logic [IW-1:0] win_line_i,
  input  logic [N-1:0]  trig_level_i,
  input  logic [VW-1:0] vec_base_i,
  input  prio_mode_t    mode_i,
  output logic [IW-1:0] ack_line_o,
  output logic [VW-1:0] vector_o,
  output logic          spurious_o,
  output logic [N-1:0]  isr_set_o,
  output logic [N-1:0]  irr_clr_o,
  output logic          ofs_upd_o,
  output logic [IW-1:0] ofs_nxt_o
);
  logic [N-1:0] win_hot;
  logic         take;

  assign take       = ack_i & win_i;
  assign win_hot    = N'(1) << win_line_i;
  assign ack_line_o = win_i ? win_line_i : IW'(N - 1);
  assign vector_o   = {vec_base_i[VW-1:IW], ack_line_o};
  assign spurious_o = ack_i & ~win_i;
  assign ofs_nxt_o  = win_line_i + IW'(1);

  always_comb begin
    isr_set_o = '0;
    irr_clr_o = '0;
    ofs_upd_o = 1'b0;
    if (take) begin
      if (!mode_i.aeoi) isr_set_o = win_hot;
      else if (mode_i.rot_aeoi) ofs_upd_o = 1'b1;
      if (!trig_level_i[win_line_i]) irr_clr_o = win_hot;
    end
  end

  // R5
  isr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(isr_set_o));
  // R7
  clr_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irr_clr_o & trig_level_i) == '0);
  // R8
  spur_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spurious_o |-> (isr_set_o == '0 && irr_clr_o == '0 && !ofs_upd_o));
  // R6
  rot_noset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofs_upd_o |-> (isr_set_o == '0 && !spurious_o));
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_res_pkg::*;
#(
  parameter int unsigned N          = 8,
  parameter int unsigned VW         = 8,
  parameter int unsigned CASC_LINE  = CASCADE_LINE_DEF,
  localparam int unsigned IW        = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  isr_i,
  input  logic [IW-1:0] ofs_i,
  input  logic [N-1:0]  trig_level_i,
  input  logic [VW-1:0] vec_base_i,
  input  logic          smask_i,
  input  logic          sfn_i,
  input  logic          master_i,
  input  logic          aeoi_i,
  input  logic          rot_aeoi_i,
  input  logic          ack_i,
  output logic          irq_o,
  output logic [IW-1:0] irq_line_o,
  output logic [IW-1:0] ack_line_o,
  output logic [VW-1:0] vector_o,
  output logic          spurious_o,
  output logic [N-1:0]  isr_set_o,
  output logic [N-1:0]  irr_clr_o,
  output logic          ofs_upd_o,
  output logic [IW-1:0] ofs_nxt_o
);
  prio_mode_t    mode;
  logic [N-1:0]  cand, svc, svc_excl;
  logic [IW:0]   req_idx, svc_idx;
  logic          win;
  logic [IW-1:0] win_line;

  assign mode = '{smask: smask_i, sfn: sfn_i, master: master_i,
                  aeoi: aeoi_i, rot_aeoi: rot_aeoi_i};

  assign cand = req_i & ~mask_i;

  always_comb begin
    svc_excl = '0;
    if (mode.smask) svc_excl = mask_i;
    if (mode.sfn && mode.master) svc_excl[CASC_LINE] = 1'b1;
  end
  assign svc = isr_i & ~svc_excl;

  prio_scan #(.N(N)) u_req_scan (.bits_i(cand), .ofs_i(ofs_i), .idx_o(req_idx));
  prio_scan #(.N(N)) u_svc_scan (.bits_i(svc),  .ofs_i(ofs_i), .idx_o(svc_idx));

  assign win      = req_idx < svc_idx;
  assign win_line = req_idx[IW-1:0] + ofs_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o      <= 1'b0;
      irq_line_o <= '0;
    end else begin
      irq_o      <= win;
      irq_line_o <= win_line;
    end
  end

  ack_unit #(.N(N), .VW(VW)) u_ack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ack_i        (ack_i),
    .win_i        (win),
    .win_line_i   (win_line),
    .trig_level_i (trig_level_i),
    .vec_base_i   (vec_base_i),
    .mode_i       (mode),
    .ack_line_o   (ack_line_o),
    .vector_o     (vector_o),
    .spurious_o   (spurious_o),
    .isr_set_o    (isr_set_o),
    .irr_clr_o    (irr_clr_o),
    .ofs_upd_o    (ofs_upd_o),
    .ofs_nxt_o    (ofs_nxt_o)
  );

  // R4
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |($past(cand) & (N'(1) << irq_line_o)));
  // R1
  req_idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand != '0) == (req_idx < (IW+1)'(N)));
endmodule

// File: tb/sim_prio_resolver.sv
module sim_prio_resolver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0, mask = '0, isr = '0, lvl = '0, base = '0;
  logic [2:0] ofs = '0;
  logic       smask = 0, sfn = 0, master = 0, aeoi = 0, rot = 0, ack = 0;
  logic       irq_o, spurious_o, ofs_upd_o;
  logic [2:0] irq_line_o, ack_line_o, ofs_nxt_o;
  logic [7:0] vector_o, isr_set_o, irr_clr_o;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  prio_resolver u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mask_i(mask), .isr_i(isr),
    .ofs_i(ofs), .trig_level_i(lvl), .vec_base_i(base), .smask_i(smask),
    .sfn_i(sfn), .master_i(master), .aeoi_i(aeoi), .rot_aeoi_i(rot),
    .ack_i(ack), .irq_o(irq_o), .irq_line_o(irq_line_o),
    .ack_line_o(ack_line_o), .vector_o(vector_o), .spurious_o(spurious_o),
    .isr_set_o(isr_set_o), .irr_clr_o(irr_clr_o), .ofs_upd_o(ofs_upd_o),
    .ofs_nxt_o(ofs_nxt_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic int rank(int l, int o);
    return (l - o + 8) % 8;
  endfunction

  task automatic run_case(string tag, logic [7:0] rq, logic [7:0] mk,
                          logic [7:0] is, logic [2:0] of, logic [7:0] lv,
                          logic [7:0] bs, logic [4:0] md, logic ak);
    int bi = 8, bl = 0, si = 8, ln;
    logic [7:0] s;
    bit w;
    @(negedge clk);
    req = rq; mask = mk; isr = is; ofs = of; lvl = lv; base = bs;
    {smask, sfn, master, aeoi, rot} = md; ack = ak;
    for (int l = 0; l < 8; l++)
      if (rq[l] && !mk[l] && rank(l, of) < bi) begin bi = rank(l, of); bl = l; end
    s = is;
    if (md[4]) s = s & ~mk;
    if (md[3] && md[2]) s[2] = 1'b0;
    for (int l = 0; l < 8; l++)
      if (s[l] && rank(l, of) < si) si = rank(l, of);
    w  = bi < si;
    ln = w ? bl : 7;
    #2;
    if (ak) begin
      chk("R8 spurious", spurious_o, !w);
      chk("R8 ack_line", ack_line_o, ln);
      chk("R9 vector", vector_o, {bs[7:3], 3'(ln)});
      chk("R5 isr_set", isr_set_o, (w && !md[1]) ? (8'd1 << bl) : 8'd0);
      chk("R7 irr_clr", irr_clr_o, (w && !lv[bl]) ? (8'd1 << bl) : 8'd0);
      chk("R6 ofs_upd", ofs_upd_o, w && md[1] && md[0]);
      if (w && md[1] && md[0]) chk("R6 ofs_nxt", ofs_nxt_o, (bl + 1) % 8);
    end
    @(posedge clk); #1;
    chk({tag, " irq"}, irq_o, w);
    if (w) chk("R1 irq_line", irq_line_o, bl);
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R4 reset irq", irq_o, 0);
    rst_n = 1'b1;
    // md = {smask, sfn, master, aeoi, rot}
    run_case("R1", 8'h81, 8'h00, 8'h00, 3'd1, 8'h00, 8'h20, 5'b00000, 1); // line 7 wins
    run_case("R1", 8'h81, 8'h00, 8'h00, 3'd0, 8'h00, 8'h20, 5'b00000, 1);
    run_case("R1", 8'h81, 8'h01, 8'h00, 3'd0, 8'h00, 8'h20, 5'b00000, 0);
    run_case("R2", 8'h10, 8'h01, 8'h01, 3'd0, 8'h00, 8'h40, 5'b10000, 1);
    run_case("R2", 8'h10, 8'h01, 8'h01, 3'd0, 8'h00, 8'h40, 5'b00000, 1);
    run_case("R3", 8'h08, 8'h00, 8'h04, 3'd0, 8'h00, 8'h08, 5'b01100, 0);
    run_case("R3", 8'h08, 8'h00, 8'h04, 3'd0, 8'h00, 8'h08, 5'b01000, 0);
    run_case("R4", 8'h10, 8'h00, 8'h10, 3'd0, 8'h00, 8'h00, 5'b00000, 0); // equal rank
    run_case("R4", 8'h00, 8'h00, 8'h00, 3'd5, 8'h00, 8'hF8, 5'b00000, 1); // spurious
    run_case("R6", 8'h80, 8'h00, 8'h00, 3'd3, 8'h80, 8'h70, 5'b00011, 1); // wrap to 0
    run_case("R7", 8'h02, 8'h00, 8'h00, 3'd0, 8'h02, 8'h10, 5'b00010, 1);
    for (int i = 0; i < 6000; i++)
      run_case("R4", 8'($urandom), 8'($urandom) & 8'($urandom), 8'($urandom) & 8'($urandom),
               3'($urandom), 8'($urandom), 8'($urandom), 5'($urandom), 1'($urandom));
    finish_run();
  end
endmodule